// File: doc/BRIEF.md
# Postincrement Memory Compare Unit

This unit executes one instruction form of a 16-bit-opcode processor: it compares two memory operands. Each operand is addressed through an address register, and that register is stepped past the operand after the read. The unit accepts a start strobe, an opcode word and a snapshot of the eight 32-bit address registers. It then runs two reads in sequence over a request/acknowledge read port. At the end it returns the stepped register values with a write mask, the N, Z, V and C flags, and the cycle charge for the instruction.

Nothing is stored except the flags. The subtraction is destination minus source. An opcode that does not match the instruction pattern, or that carries the reserved size code, is rejected with a one-cycle illegal indication. A rejected opcode issues no read and updates no register or flag.

Top module: `cmpm_unit`

## Requirements
- R1: An opcode is legal only if bits 15:12 are 1011, bit 8 is 1, bits 5:3 are 001 and the size field (bits 7:6) is not 3. Bits 11:9 name the destination register and bits 2:0 name the source register. For an illegal opcode, illegal_o pulses high with busy_o in the cycle after start. It issues no read, raises no write mask and leaves the flags unchanged.
- R2: The first read uses the address in the source register. The second read uses the address in the destination register. When both fields name the same register, the second read uses the address after the first step.
- R3: rd_req_o stays high and rd_addr_o stays unchanged until rd_ack_i is seen on a clock edge. rd_size_o uses the encoding 0 byte, 1 word, 2 long. The operand is taken from the low 8, 16 or 32 bits of rd_data_i.
- R4: After each read, the register used is stepped by 1 for byte, 2 for word and 4 for long. A byte read through register 7 steps it by 2.
- R5: When done_o is high, areg_we_o has exactly the bits of the source and destination registers set. areg_o carries the stepped values, and every other register keeps its input value. areg_we_o is zero at all other times.
- R6: N equals the top bit of the difference at the operation size. Z is set when the difference at that size is zero.
- R7: V is set when the signed difference falls outside the signed range of the size. C is set when the unsigned destination is less than the unsigned source.
- R8: cycles_o reports 12 for byte and word and 20 for long. The value is valid from the cycle in which done_o is high.
- R9: The flags change only on the clock edge that accepts the second read. done_o is high for exactly one cycle, directly after that edge.
- R10: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted while idle |
| opcode_i | input | 16 | Instruction word |
| areg_i | input | 256 | Address registers, register n in bits 32n+31:32n |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | One-cycle illegal-opcode strobe |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address |
| rd_size_o | output | 2 | Read size |
| rd_ack_i | input | 1 | Read accepted, data valid |
| rd_data_i | input | 32 | Read data, operand right-aligned |
| areg_o | output | 256 | Updated address registers |
| areg_we_o | output | 8 | Register write mask, valid with done_o |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Borrow flag |
| cycles_o | output | 5 | Cycle charge of the last instruction |

## Verification
A start taken on edge k gives the first request at edge k, visible one cycle later. An illegal opcode shows illegal_o in that same cycle instead of a request. Each acknowledge is consumed on the next edge, so the following request or result appears one cycle after the acknowledge is driven. done_o, the flags, the cycle charge and the write mask must appear exactly one cycle after the second acknowledge, and done_o must be low again in the cycle after that. The bench drives and samples on the falling edge. It compares request address and size on every cycle of a pending read, under acknowledge latencies of 0 to 3 cycles. On every cycle without done_o it also confirms that the flags have not moved.

// File: rtl/cmpm_pkg.sv
package cmpm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC,
    ST_DST,
    ST_FIN,
    ST_ILL
  } state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/cmpm_decode.sv
module cmpm_decode
  import cmpm_pkg::*;
(
  input  logic [15:0] op_i,
  output logic [2:0]  dst_o,
  output logic [2:0]  src_o,
  output size_e       size_o,
  output logic        legal_o
);
  logic pattern_ok;

  assign dst_o  = op_i[11:9];
  assign src_o  = op_i[2:0];
  assign size_o = size_e'(op_i[7:6]);

  assign pattern_ok = (op_i[15:12] == 4'b1011) && op_i[8] && (op_i[5:3] == 3'b001);
  assign legal_o    = pattern_ok && (op_i[7:6] != 2'b11);
endmodule

// File: rtl/cmpm_step.sv
module cmpm_step
  import cmpm_pkg::*;
#(
  parameter int          AW     = 32,
  parameter int          RW     = 3,
  parameter logic [2:0]  SP_IDX = 3'd7
) (
  input  size_e          size_i,
  input  logic [RW-1:0]  idx_i,
  output logic [AW-1:0]  step_o
);
  // stack register stays word aligned on byte accesses
  always_comb begin
    unique case (size_i)
      SZ_BYTE: step_o = (idx_i == RW'(SP_IDX)) ? AW'(2) : AW'(1);
      SZ_WORD: step_o = AW'(2);
      default: step_o = AW'(4);
    endcase
  end
endmodule

// File: rtl/cmpm_flags.sv
module cmpm_flags
  import cmpm_pkg::*;
#(
  parameter int DW = 32
) (
  input  size_e          size_i,
  input  logic [DW-1:0]  src_i,
  input  logic [DW-1:0]  dst_i,
  output ccr_t           ccr_o
);
  localparam int NLANE = 3;

  logic [NLANE-1:0] n_l, z_l, v_l, c_l;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = DW >> (NLANE - 1 - g);
    logic [LW:0] diff;
    assign diff   = {1'b0, dst_i[LW-1:0]} - {1'b0, src_i[LW-1:0]};
    assign n_l[g] = diff[LW-1];
    assign z_l[g] = (diff[LW-1:0] == '0);
    assign c_l[g] = diff[LW];
    assign v_l[g] = (dst_i[LW-1] ^ src_i[LW-1]) & (diff[LW-1] ^ dst_i[LW-1]);
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: ccr_o = '{n: n_l[0], z: z_l[0], v: v_l[0], c: c_l[0]};
      SZ_WORD: ccr_o = '{n: n_l[1], z: z_l[1], v: v_l[1], c: c_l[1]};
      default: ccr_o = '{n: n_l[2], z: z_l[2], v: v_l[2], c: c_l[2]};
    endcase
  end
endmodule

// File: rtl/cmpm_unit.sv
module cmpm_unit
  import cmpm_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CYC_W     = 5,
  parameter int CYC_SHORT = 12,
  parameter int CYC_LONG  = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [15:0]          opcode_i,
  input  logic [8*AW-1:0]      areg_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 illegal_o,
  output logic                 rd_req_o,
  output logic [AW-1:0]        rd_addr_o,
  output logic [1:0]           rd_size_o,
  input  logic                 rd_ack_i,
  input  logic [DW-1:0]        rd_data_i,
  output logic [8*AW-1:0]      areg_o,
  output logic [7:0]           areg_we_o,
  output logic                 flag_n_o,
  output logic                 flag_z_o,
  output logic                 flag_v_o,
  output logic                 flag_c_o,
  output logic [CYC_W-1:0]     cycles_o
);
  localparam int         RW     = 3;
  localparam int         NREG   = 1 << RW;
  localparam logic [2:0] SP_IDX = 3'(NREG - 1);

  state_e           state_q;
  size_e            size_q;
  logic [RW-1:0]    src_idx_q, dst_idx_q;
  logic [AW-1:0]    areg_q [NREG];
  logic [DW-1:0]    src_data_q;
  ccr_t             ccr_q;
  logic [CYC_W-1:0] cycles_q;
  logic [NREG-1:0]  we_q;

  logic [2:0]       dec_dst, dec_src;
  size_e            dec_size;
  logic             dec_legal;
  logic [RW-1:0]    cur_idx;
  logic [AW-1:0]    step;
  ccr_t             ccr_new;
  logic             accept;

  cmpm_decode u_decode (
    .op_i    (opcode_i),
    .dst_o   (dec_dst),
    .src_o   (dec_src),
    .size_o  (dec_size),
    .legal_o (dec_legal)
  );

  assign cur_idx = (state_q == ST_SRC) ? src_idx_q : dst_idx_q;

  cmpm_step #(.AW(AW), .RW(RW), .SP_IDX(SP_IDX)) u_step (
    .size_i (size_q),
    .idx_i  (cur_idx),
    .step_o (step)
  );

  cmpm_flags #(.DW(DW)) u_flags (
    .size_i (size_q),
    .src_i  (src_data_q),
    .dst_i  (rd_data_i),
    .ccr_o  (ccr_new)
  );

  assign accept = rd_req_o && rd_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      size_q     <= SZ_BYTE;
      src_idx_q  <= '0;
      dst_idx_q  <= '0;
      src_data_q <= '0;
      ccr_q      <= '0;
      cycles_q   <= '0;
      we_q       <= '0;
      for (int i = 0; i < NREG; i++) areg_q[i] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          size_q    <= dec_size;
          src_idx_q <= dec_src;
          dst_idx_q <= dec_dst;
          for (int i = 0; i < NREG; i++) areg_q[i] <= areg_i[i*AW +: AW];
          state_q   <= dec_legal ? ST_SRC : ST_ILL;
        end
        ST_SRC: if (accept) begin
          src_data_q       <= rd_data_i;
          areg_q[cur_idx]  <= areg_q[cur_idx] + step;
          state_q          <= ST_DST;
        end
        ST_DST: if (accept) begin
          areg_q[cur_idx]  <= areg_q[cur_idx] + step;
          ccr_q            <= ccr_new;
          cycles_q         <= (size_q == SZ_LONG) ? CYC_W'(CYC_LONG) : CYC_W'(CYC_SHORT);
          we_q             <= (NREG'(1) << src_idx_q) | (NREG'(1) << dst_idx_q);
          state_q          <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FIN);
  assign illegal_o = (state_q == ST_ILL);
  assign rd_req_o  = (state_q == ST_SRC) || (state_q == ST_DST);
  assign rd_addr_o = areg_q[cur_idx];
  assign rd_size_o = size_q;
  assign areg_we_o = done_o ? we_q : '0;
  assign flag_n_o  = ccr_q.n;
  assign flag_z_o  = ccr_q.z;
  assign flag_v_o  = ccr_q.v;
  assign flag_c_o  = ccr_q.c;
  assign cycles_o  = cycles_q;

  for (genvar i = 0; i < NREG; i++) begin : g_pack
    assign areg_o[i*AW +: AW] = areg_q[i];
  end

  p_legal_size_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && dec_legal) |-> (dec_size != SZ_BAD));

  p_ill_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!rd_req_o && !done_o && areg_we_o == '0));

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  p_step_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> $onehot(step));

  p_zero_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DST && rd_ack_i && ccr_new.z) |-> (!ccr_new.n && !ccr_new.c && !ccr_new.v));

  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_q == ST_DST && rd_ack_i) |=> $stable(ccr_q));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(src_idx_q) && $stable(dst_idx_q) && $stable(size_q)));
endmodule

// File: tb/cmpm_unit_tb_top.sv
`timescale 1ns/1ps
module cmpm_unit_tb_top;
  localparam int HALF = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [255:0] areg_i;
  logic        busy_o, done_o, illegal_o, rd_req_o;
  logic [31:0] rd_addr_o;
  logic [1:0]  rd_size_o;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic [255:0] areg_o;
  logic [7:0]  areg_we_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;
  logic [4:0]  cycles_o;

  logic [31:0] breg [8];
  logic [3:0]  exp_ccr = 4'b0000;
  int checks = 0;
  int errors = 0;

  always #(HALF) clk_i = ~clk_i;

  for (genvar i = 0; i < 8; i++) begin : g_drv
    assign areg_i[i*32 +: 32] = breg[i];
  end

  cmpm_unit dut_i (
    .clk_i, .rst_ni, .start_i, .opcode_i, .areg_i,
    .busy_o, .done_o, .illegal_o,
    .rd_req_o, .rd_addr_o, .rd_size_o, .rd_ack_i, .rd_data_i,
    .areg_o, .areg_we_o,
    .flag_n_o, .flag_z_o, .flag_v_o, .flag_c_o, .cycles_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int x, input int sz, input int y);
    return {4'b1011, 3'(x), 1'b1, 2'(sz), 3'b001, 3'(y)};
  endfunction

  function automatic logic [31:0] stp(input int sz, input int r);
    if (sz == 0) return (r == 7) ? 32'd2 : 32'd1;
    if (sz == 1) return 32'd2;
    return 32'd4;
  endfunction

  task automatic run_op(input logic [15:0] op, input logic [31:0] sv, input logic [31:0] dv,
                        input int lat, input bit poke);
    int x, y, sz, rd, w, ack2;
    bit legal, fin;
    logic [31:0] e [8];
    logic [31:0] ea [2];
    longint su, du, ss, ds, r, lim;
    int wdt;
    logic [3:0] nccr;
    logic [7:0] emask;
    x = int'(op[11:9]); y = int'(op[2:0]); sz = int'(op[7:6]);
    legal = (op[15:12] == 4'b1011) && op[8] && (op[5:3] == 3'b001) && (sz != 3);
    for (int i = 0; i < 8; i++) e[i] = breg[i];
    ea[0] = e[y]; e[y] = e[y] + stp(sz, y);
    ea[1] = e[x]; e[x] = e[x] + stp(sz, x);
    case (sz)
      0: begin su = longint'(sv[7:0]); du = longint'(dv[7:0]);
               ss = longint'($signed(sv[7:0])); ds = longint'($signed(dv[7:0])); end
      1: begin su = longint'(sv[15:0]); du = longint'(dv[15:0]);
               ss = longint'($signed(sv[15:0])); ds = longint'($signed(dv[15:0])); end
      default: begin su = longint'(sv); du = longint'(dv);
               ss = longint'($signed(sv)); ds = longint'($signed(dv)); end
    endcase
    wdt = 8 << ((sz > 2) ? 2 : sz);
    lim = longint'(1) <<< (wdt - 1);
    r = ds - ss;
    nccr[3] = r[wdt-1];
    nccr[2] = ((r & ((lim <<< 1) - 1)) == 0);
    nccr[1] = (r > lim - 1) || (r < -lim);
    nccr[0] = (du - su) < 0;
    emask = (8'd1 << x) | (8'd1 << y);

    @(negedge clk_i);
    opcode_i = op; start_i = 1'b1;
    rd = 0; w = 0; ack2 = -10; fin = 0;
    for (int cyc = 0; cyc < 40 && !fin; cyc++) begin
      @(negedge clk_i);
      rd_ack_i = 1'b0;
      start_i = poke && (cyc == 0);
      if (poke && cyc == 0) opcode_i = 16'hBFCF;
      if (!legal) begin
        if (cyc == 0) begin
          chk(illegal_o && busy_o, "R1 illegal strobe", {illegal_o, busy_o}, 2'b11);
          chk(!rd_req_o && !done_o && areg_we_o == 0, "R1 no read/write", {rd_req_o, done_o, areg_we_o}, 0);
        end else begin
          chk(!illegal_o && !busy_o, "R1 strobe ends", {illegal_o, busy_o}, 0);
          fin = 1;
        end
      end else if (done_o) begin
        chk(cyc == ack2 + 1, "R9 done timing", cyc, ack2 + 1);
        chk({flag_n_o, flag_z_o} == nccr[3:2], "R6 N/Z", {flag_n_o, flag_z_o}, nccr[3:2]);
        chk({flag_v_o, flag_c_o} == nccr[1:0], "R7 V/C", {flag_v_o, flag_c_o}, nccr[1:0]);
        chk(cycles_o == ((sz == 2) ? 5'd20 : 5'd12), "R8 cycles", cycles_o, (sz == 2) ? 20 : 12);
        chk(areg_we_o == emask, "R5 write mask", areg_we_o, emask);
        for (int i = 0; i < 8; i++)
          chk(areg_o[i*32 +: 32] == e[i], "R4 register value", areg_o[i*32 +: 32], e[i]);
        for (int i = 0; i < 8; i++) breg[i] = e[i];
        exp_ccr = nccr;
        fin = 1;
      end else begin
        if (rd_req_o) begin
          if (rd > 1) chk(0, "R2 extra read", rd, 2);
          else begin
            chk(rd_addr_o == ea[rd], (w == 0) ? "R2 read address" : "R3 address held", rd_addr_o, ea[rd]);
            chk(rd_size_o == 2'(sz), "R3 read size", rd_size_o, sz);
            if (w == lat) begin
              rd_ack_i = 1'b1;
              rd_data_i = (rd == 0) ? sv : dv;
              if (rd == 1) ack2 = cyc;
              rd++; w = 0;
            end else w++;
          end
        end
      end
      if (!done_o)
        chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == exp_ccr, "R9 flags hold",
            {flag_n_o, flag_z_o, flag_v_o, flag_c_o}, exp_ccr);
    end
    if (!fin) chk(0, "R9 no completion", 0, 1);
    @(negedge clk_i);
    rd_ack_i = 1'b0; start_i = 1'b0;
    chk(!done_o && !busy_o && areg_we_o == 0, "R9 done single pulse", {done_o, busy_o, areg_we_o}, 0);
    chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == exp_ccr, "R9 flags after", 
        {flag_n_o, flag_z_o, flag_v_o, flag_c_o}, exp_ccr);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) breg[i] = 32'h1000_0000 + 32'h100 * i;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !illegal_o && !rd_req_o, "R9 reset idle",
        {busy_o, done_o, illegal_o, rd_req_o}, 0);
    chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o} == 0 && areg_we_o == 0, "R9 reset flags",
        {flag_n_o, flag_z_o, flag_v_o, flag_c_o}, 0);

    run_op(mk(1, 0, 2), 32'hFFFF_FF33, 32'h1234_5633, 0, 0); // R6 byte equal, R3 upper bits ignored
    run_op(mk(3, 0, 4), 32'h0000_0001, 32'h0000_0080, 1, 0); // R7 byte overflow
    run_op(mk(2, 0, 5), 32'h0000_0001, 32'h0000_0000, 2, 0); // R7 borrow, R6 negative
    run_op(mk(1, 0, 7), 32'h0000_0010, 32'h0000_0020, 0, 0); // R4 src stack step 2
    run_op(mk(7, 0, 6), 32'h0000_0020, 32'h0000_0010, 1, 0); // R4 dst stack step 2
    run_op(mk(7, 0, 7), 32'h0000_0005, 32'h0000_0005, 0, 0); // R4 both stack
    run_op(mk(3, 1, 3), 32'hABCD_8000, 32'h0000_7FFF, 1, 0); // R2 same register, word
    run_op(mk(0, 2, 1), 32'h0000_0001, 32'h8000_0000, 3, 0); // R8 long, R7 overflow
    run_op(mk(4, 2, 5), 32'h0000_0002, 32'h0000_0001, 0, 0); // R7 long borrow
    run_op(mk(5, 2, 5), 32'h1234_5678, 32'h1234_5678, 2, 0); // R6 long equal, same reg
    run_op(mk(1, 3, 2), 32'h0, 32'h0, 0, 0);                 // R1 reserved size
    run_op(16'hB24A, 32'h0, 32'h0, 0, 0);                    // R1 bit 8 clear
    run_op(16'hB302, 32'h0, 32'h0, 0, 0);                    // R1 wrong mode field
    run_op(mk(6, 1, 0), 32'h0000_1234, 32'h0000_1235, 1, 1); // R10 start while busy
    run_op(mk(2, 2, 3), 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, 0); // R7 long: V and C

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule